// File: doc/BRIEF.md
# Performance Counter Access Gate

This block sits beside the CSR decoder of a hart and decides whether an instruction that touches a performance counter address may proceed. Each request carries the current privilege (machine, supervisor or user), the 12-bit CSR address and whether it writes. The block sorts the address into one of three families: the read-only user views of the counters, the machine counters, and the event selectors. It then applies a chain of enable masks. The machine enable mask gates the supervisor level. The supervisor enable mask further gates the user level. A delegation switch can hand selected machine counters and event selectors to the supervisor for both reading and writing, so that tuning code avoids a round trip through machine mode.

The block produces exactly one of two results: an allow, or an illegal-instruction trap request. Addresses outside the counter families produce neither, so another decoder can claim them. On an allowed access, a select tells the datapath which backing counter, which half, or the external wall-clock time value to return. Internally a decision takes one of four named states. DEC_IDLE means there is no request. DEC_PASS means the address is foreign. DEC_ALLOW and DEC_TRAP are the two verdicts. The output stage is either transparent or a single register, chosen by the `REG_OUT` parameter. In the registered variant, the transition from a verdict to the ports takes one clock, and reset forces every output to zero.

Top module: `ctr_access_gate`

## Requirements
- R1: Address families use the low 5 address bits as the counter number N. The user views are 0xC00–0xC1F, and 0xC80–0xC9F as upper halves. The machine counters are 0xB00 and 0xB02–0xB1F, and 0xB80 and 0xB82–0xB9F as upper halves. The event selectors are 0x323–0x33F. Any other address, including 0xB01, 0xB81 and 0x320–0x322, gives acc_ok=0 and acc_trap=0.
- R2: A write to any user-view address traps at every privilege level.
- R3: Privilege encoding is 0 for user, 1 for supervisor, 3 for machine, and 2 behaves as user. Machine privilege is allowed every counter-family access except the writes of R2.
- R4: A supervisor read of user view N is allowed when bit N of m_en_mask is set, and traps otherwise.
- R5: A user read of user view N is allowed only when bit N of both m_en_mask and s_en_mask is set, and traps otherwise.
- R6: A machine counter or event selector N traps at user level. At supervisor level it traps unless deleg_en=1 and bit N of m_en_mask is set; in that case both reads and writes are allowed.
- R7: With req_valid=0, both acc_ok and acc_trap are 0. The two are never 1 together.
- R8: On an allowed access, sel_kind is 1 for a counter, 2 for the time view (user view N=1) and 3 for an event selector. sel_idx is N and sel_hi marks an upper-half address. When the access is not allowed, all three are 0.
- R9: time_val equals mtime_in when sel_kind=2 and is 0 otherwise.
- R10: With REG_OUT=0, the outputs follow the request in the same cycle. With REG_OUT=1, they appear one clock later, and they are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A CSR access is presented |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_addr | input | 12 | CSR address |
| req_wr | input | 1 | Access writes the CSR |
| m_en_mask | input | 32 | Machine-level per-counter enables for the supervisor |
| s_en_mask | input | 32 | Supervisor-level per-counter enables for the user |
| deleg_en | input | 1 | Counter delegation to supervisor switched on |
| mtime_in | input | TIME_W | External wall-clock time value |
| acc_ok | output | 1 | Access permitted |
| acc_trap | output | 1 | Illegal-instruction trap request |
| sel_kind | output | 2 | Read source kind: 0 none, 1 counter, 2 time, 3 event selector |
| sel_idx | output | 5 | Counter number N |
| sel_hi | output | 1 | Upper half of the counter selected |
| time_val | output | TIME_W | Time value routed for an allowed time read |

## Verification
A wrong decision state shows directly at the ports. A wrongly classified address appears as a trap where a pass-through was due, or the reverse. A mask bit taken from the wrong position flips acc_ok for a single counter number. The fault is visible in the same cycle as the request, or one clock later with the registered stage, so the bench compares every output field on every vector. It sweeps each address in and around every family, across all privilege codes, both write intents, several mask patterns and both delegation settings. It checks the registered instance on the same vectors with a one-vector lag.

// File: rtl/ctr_gate_pkg.sv
package ctr_gate_pkg;

    localparam int ADDR_W        = 12;
    localparam int NCTR          = 32;
    localparam int IDX_W         = $clog2(NCTR);

    localparam int ALIAS_BASE    = 'hC00;
    localparam int ALIAS_HI_BASE = 'hC80;
    localparam int MCTR_BASE     = 'hB00;
    localparam int MCTR_HI_BASE  = 'hB80;
    localparam int EVT_BASE      = 'h320;
    localparam int TIME_IDX      = 1;
    localparam int EVT_FIRST     = 3;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ALIAS = 2'd1,
        CLS_MCTR  = 2'd2,
        CLS_EVT   = 2'd3
    } addr_cls_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTR  = 2'd1,
        SEL_TIME = 2'd2,
        SEL_EVT  = 2'd3
    } sel_kind_e;

    typedef enum logic [1:0] {
        DEC_IDLE  = 2'd0,
        DEC_PASS  = 2'd1,
        DEC_ALLOW = 2'd2,
        DEC_TRAP  = 2'd3
    } dec_e;

    typedef struct packed {
        logic             ok;
        logic             trap;
        sel_kind_e        sel;
        logic [IDX_W-1:0] idx;
        logic             hi;
    } acc_res_t;

endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode
    import ctr_gate_pkg::*;
#(
    parameter bit HAS_HI = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_cls_e         cls,
    output logic [IDX_W-1:0]  idx,
    output logic              hi
);

    localparam int BLK_W = ADDR_W - IDX_W;
    localparam logic [BLK_W-1:0] B_ALIAS    = BLK_W'(ALIAS_BASE >> IDX_W);
    localparam logic [BLK_W-1:0] B_ALIAS_HI = BLK_W'(ALIAS_HI_BASE >> IDX_W);
    localparam logic [BLK_W-1:0] B_MCTR     = BLK_W'(MCTR_BASE >> IDX_W);
    localparam logic [BLK_W-1:0] B_MCTR_HI  = BLK_W'(MCTR_HI_BASE >> IDX_W);
    localparam logic [BLK_W-1:0] B_EVT      = BLK_W'(EVT_BASE >> IDX_W);
    localparam logic [IDX_W-1:0] I_TIME     = IDX_W'(TIME_IDX);
    localparam logic [IDX_W-1:0] I_EVT0     = IDX_W'(EVT_FIRST);

    logic [BLK_W-1:0] blk;

    assign blk = addr[ADDR_W-1:IDX_W];
    assign idx = addr[IDX_W-1:0];

    always_comb begin
        cls = CLS_NONE;
        hi  = 1'b0;
        if (blk == B_ALIAS) begin
            cls = CLS_ALIAS;
        end else if (HAS_HI && blk == B_ALIAS_HI) begin
            cls = CLS_ALIAS;
            hi  = 1'b1;
        end else if (blk == B_MCTR && idx != I_TIME) begin
            cls = CLS_MCTR;
        end else if (HAS_HI && blk == B_MCTR_HI && idx != I_TIME) begin
            cls = CLS_MCTR;
            hi  = 1'b1;
        end else if (blk == B_EVT && idx >= I_EVT0) begin
            cls = CLS_EVT;
        end
    end

endmodule

// File: rtl/ctr_priv_gate.sv
module ctr_priv_gate
    import ctr_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [1:0]       priv,
    input  logic             wr,
    input  addr_cls_e        cls,
    input  logic [IDX_W-1:0] idx,
    input  logic [NCTR-1:0]  m_en,
    input  logic [NCTR-1:0]  s_en,
    input  logic             deleg_en,
    output dec_e             dec
);

    logic grant;

    always_comb begin
        grant = 1'b0;
        unique case (cls)
            CLS_NONE: grant = 1'b0;
            CLS_ALIAS: begin
                if (wr)                  grant = 1'b0;
                else if (priv == PRIV_M) grant = 1'b1;
                else if (priv == PRIV_S) grant = m_en[idx];
                else                     grant = m_en[idx] & s_en[idx];
            end
            CLS_MCTR, CLS_EVT: begin
                if (priv == PRIV_M)      grant = 1'b1;
                else if (priv == PRIV_S) grant = deleg_en & m_en[idx];
                else                     grant = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (!valid)                dec = DEC_IDLE;
        else if (cls == CLS_NONE)  dec = DEC_PASS;
        else if (grant)            dec = DEC_ALLOW;
        else                       dec = DEC_TRAP;
    end

    AST_ALIAS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cls == CLS_ALIAS && wr) |-> (dec == DEC_TRAP)); // R2
    AST_SUP_NEEDS_MEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && priv == PRIV_S && cls != CLS_NONE && !m_en[idx]) |-> (dec == DEC_TRAP)); // R4
    AST_USER_NEEDS_SEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && priv == PRIV_U && cls == CLS_ALIAS && !s_en[idx]) |-> (dec == DEC_TRAP)); // R5
    AST_USER_NO_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && priv == PRIV_U && (cls == CLS_MCTR || cls == CLS_EVT)) |-> (dec == DEC_TRAP)); // R6
    AST_MACHINE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && priv == PRIV_M && cls != CLS_NONE && !(cls == CLS_ALIAS && wr)) |-> (dec == DEC_ALLOW)); // R3

endmodule

// File: rtl/ctr_out_stage.sv
module ctr_out_stage
    import ctr_gate_pkg::*;
#(
    parameter bit REG_OUT = 1'b0,
    parameter int TIME_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_res_t          res_d,
    input  logic [TIME_W-1:0] tval_d,
    output acc_res_t          res_q,
    output logic [TIME_W-1:0] tval_q
);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q  <= '0;
                    tval_q <= '0;
                end else begin
                    res_q  <= res_d;
                    tval_q <= tval_d;
                end
            end
        end else begin : g_comb
            assign res_q  = res_d;
            assign tval_q = tval_d;
        end
    endgenerate

    AST_STAGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_q.ok && res_q.trap)); // R7

endmodule

// File: rtl/ctr_access_gate.sv
module ctr_access_gate
    import ctr_gate_pkg::*;
#(
    parameter bit REG_OUT = 1'b0,
    parameter bit HAS_HI  = 1'b1,
    parameter int TIME_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_priv,
    input  logic [11:0]       req_addr,
    input  logic              req_wr,
    input  logic [31:0]       m_en_mask,
    input  logic [31:0]       s_en_mask,
    input  logic              deleg_en,
    input  logic [TIME_W-1:0] mtime_in,
    output logic              acc_ok,
    output logic              acc_trap,
    output logic [1:0]        sel_kind,
    output logic [4:0]        sel_idx,
    output logic              sel_hi,
    output logic [TIME_W-1:0] time_val
);

    localparam logic [IDX_W-1:0] I_TIME = IDX_W'(TIME_IDX);

    addr_cls_e         cls;
    logic [IDX_W-1:0]  idx;
    logic              hi;
    dec_e              dec;
    acc_res_t          res_d;
    acc_res_t          res_q;
    logic [TIME_W-1:0] tval_d;

    ctr_addr_decode #(.HAS_HI(HAS_HI)) u_dec (
        .addr (req_addr),
        .cls  (cls),
        .idx  (idx),
        .hi   (hi)
    );

    ctr_priv_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (req_valid),
        .priv     (req_priv),
        .wr       (req_wr),
        .cls      (cls),
        .idx      (idx),
        .m_en     (m_en_mask),
        .s_en     (s_en_mask),
        .deleg_en (deleg_en),
        .dec      (dec)
    );

    always_comb begin
        res_d      = '0;
        tval_d     = '0;
        res_d.trap = (dec == DEC_TRAP);
        if (dec == DEC_ALLOW) begin
            res_d.ok  = 1'b1;
            res_d.idx = idx;
            res_d.hi  = hi;
            unique case (cls)
                CLS_ALIAS: res_d.sel = (idx == I_TIME) ? SEL_TIME : SEL_CTR;
                CLS_MCTR:  res_d.sel = SEL_CTR;
                CLS_EVT:   res_d.sel = SEL_EVT;
                CLS_NONE:  res_d.sel = SEL_NONE;
            endcase
            if (res_d.sel == SEL_TIME) tval_d = mtime_in;
        end
    end

    ctr_out_stage #(.REG_OUT(REG_OUT), .TIME_W(TIME_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .res_d  (res_d),
        .tval_d (tval_d),
        .res_q  (res_q),
        .tval_q (time_val)
    );

    assign acc_ok   = res_q.ok;
    assign acc_trap = res_q.trap;
    assign sel_kind = res_q.sel;
    assign sel_idx  = res_q.idx;
    assign sel_hi   = res_q.hi;

    AST_SEL_ZERO_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ok |-> (sel_kind == 2'd0 && sel_idx == 5'd0 && !sel_hi)); // R8
    AST_TIME_ONLY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (time_val != '0) |-> (sel_kind == 2'd2)); // R9
    AST_OK_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_ok && acc_trap)); // R7

    generate
        if (REG_OUT) begin : g_chk_reg
            AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
                !req_valid |=> (!acc_ok && !acc_trap)); // R7
            AST_REG_LAG: assert property (@(posedge clk) disable iff (!rst_n)
                (dec == DEC_TRAP) |=> acc_trap); // R10
        end else begin : g_chk_comb
            AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
                !req_valid |-> (!acc_ok && !acc_trap)); // R7
            AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                (dec == DEC_TRAP) |-> acc_trap); // R10
        end
    endgenerate

endmodule

// File: tb/sim_ctr_access_gate.sv
module sim_ctr_access_gate;

    typedef struct packed {
        logic        ok;
        logic        trap;
        logic [1:0]  sel;
        logic [4:0]  idx;
        logic        hi;
        logic [63:0] tv;
    } res_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_priv = 2'd0;
    logic [11:0] req_addr = 12'd0;
    logic        req_wr = 1'b0;
    logic [31:0] m_en_mask = 32'd0;
    logic [31:0] s_en_mask = 32'd0;
    logic        deleg_en = 1'b0;
    logic [63:0] mtime_in = 64'd0;

    logic        ok0, trap0, hi0, ok1, trap1, hi1;
    logic [1:0]  sel0, sel1;
    logic [4:0]  idx0, idx1;
    logic [63:0] tv0, tv1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ctr_access_gate #(.REG_OUT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
        .req_addr(req_addr), .req_wr(req_wr), .m_en_mask(m_en_mask),
        .s_en_mask(s_en_mask), .deleg_en(deleg_en), .mtime_in(mtime_in),
        .acc_ok(ok0), .acc_trap(trap0), .sel_kind(sel0), .sel_idx(idx0),
        .sel_hi(hi0), .time_val(tv0));

    ctr_access_gate #(.REG_OUT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
        .req_addr(req_addr), .req_wr(req_wr), .m_en_mask(m_en_mask),
        .s_en_mask(s_en_mask), .deleg_en(deleg_en), .mtime_in(mtime_in),
        .acc_ok(ok1), .acc_trap(trap1), .sel_kind(sel1), .sel_idx(idx1),
        .sel_hi(hi1), .time_val(tv1));

    function automatic int kind_of(input logic [11:0] a);
        int n;
        logic [11:0] base;
        n    = int'(a[4:0]);
        base = {a[11:5], 5'd0};
        if (base == 12'hC00 || base == 12'hC80) return 1;
        if ((base == 12'hB00 || base == 12'hB80) && n != 1) return 2;
        if (base == 12'h320 && n >= 3) return 3;
        return 0;
    endfunction

    function automatic res_t model(input logic v, input logic [1:0] p, input logic [11:0] a,
                                   input logic w, input logic [31:0] me, input logic [31:0] se,
                                   input logic dl, input logic [63:0] mt);
        res_t r;
        int   k;
        int   n;
        logic g;
        r = '0;
        k = kind_of(a);
        n = int'(a[4:0]);
        if (!v || k == 0) return r;
        if (k == 1) begin
            if (w)           g = 1'b0;
            else if (p == 3) g = 1'b1;
            else if (p == 1) g = me[n];
            else             g = me[n] & se[n];
        end else begin
            if (p == 3)      g = 1'b1;
            else if (p == 1) g = dl & me[n];
            else             g = 1'b0;
        end
        if (!g) begin
            r.trap = 1'b1;
            return r;
        end
        r.ok  = 1'b1;
        r.idx = a[4:0];
        r.hi  = (a[7] == 1'b1);
        if (k == 3)                r.sel = 2'd3;
        else if (k == 1 && n == 1) r.sel = 2'd2;
        else                       r.sel = 2'd1;
        if (r.sel == 2'd2) r.tv = mt;
        return r;
    endfunction

    function automatic string tag_of(input logic v, input logic [1:0] p,
                                     input logic [11:0] a, input logic w);
        int k;
        k = kind_of(a);
        if (!v)                 return "R7";
        if (k == 0)             return "R1";
        if (k == 1 && w)        return "R2";
        if (p == 3)             return "R3 R8 R9";
        if (k == 1 && p == 1)   return "R4 R8 R9";
        if (k == 1)             return "R5 R8 R9";
        return "R6 R8";
    endfunction

    task automatic compare(input string tag, input string which, input res_t got, input res_t exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s addr=%h priv=%0d wr=%0d got ok=%0d trap=%0d sel=%0d idx=%0d hi=%0d tv=%h exp ok=%0d trap=%0d sel=%0d idx=%0d hi=%0d tv=%h",
                     tag, which, req_addr, req_priv, req_wr,
                     got.ok, got.trap, got.sel, got.idx, got.hi, got.tv,
                     exp.ok, exp.trap, exp.sel, exp.idx, exp.hi, exp.tv);
        end
    endtask

    function automatic res_t got0();
        return {ok0, trap0, sel0, idx0, hi0, tv0};
    endfunction

    function automatic res_t got1();
        return {ok1, trap1, sel1, idx1, hi1, tv1};
    endfunction

    res_t prev_exp = '0;
    string prev_tag = "R10";

    task automatic apply(input logic v, input logic [1:0] p, input logic [11:0] a, input logic w);
        res_t  e;
        string t;
        @(negedge clk);
        req_valid = v;
        req_priv  = p;
        req_addr  = a;
        req_wr    = w;
        mtime_in  = mtime_in + 64'h0000_0001_0000_0003;
        #2;
        e = model(v, p, a, w, m_en_mask, s_en_mask, deleg_en, mtime_in);
        t = tag_of(v, p, a, w);
        compare(t, "R10 comb", got0(), e);
        compare(prev_tag, "R10 registered lag", got1(), prev_exp);
        prev_exp = e;
        prev_tag = t;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int starts [6];
        int lens   [6];
        logic [31:0] mpat [3];
        logic [31:0] spat [3];
        starts = '{'h318, 'hAF8, 'hB78, 'hBF8, 'hC78, 'hCA0};
        lens   = '{40, 40, 40, 40, 48, 8};
        mpat   = '{32'hFFFF_FFFF, 32'h5A5A_C3A7, 32'h0000_0000};
        spat   = '{32'hAAAA_AAAA, 32'hF0F0_3C5F, 32'hFFFF_FFFF};
        mtime_in = 64'h0123_4567_89AB_CDEF;

        req_valid = 1'b1;
        req_priv  = 2'd3;
        req_addr  = 12'hC01;
        m_en_mask = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        compare("R10", "reset registered", got1(), '0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;
        #2;
        compare("R7", "reset comb idle", got0(), '0);
        compare("R10", "post reset registered", got1(), '0);

        for (int pt = 0; pt < 3; pt++) begin
            for (int d = 0; d < 2; d++) begin
                m_en_mask = mpat[pt];
                s_en_mask = spat[pt];
                deleg_en  = d[0];
                for (int pr = 0; pr < 4; pr++) begin
                    for (int b = 0; b < 6; b++) begin
                        for (int o = 0; o < lens[b]; o++) begin
                            for (int w = 0; w < 2; w++) begin
                                apply(1'b1, pr[1:0], 12'(starts[b] + o), w[0]);
                            end
                        end
                    end
                end
            end
        end

        m_en_mask = 32'hFFFF_FFFF;
        s_en_mask = 32'hFFFF_FFFF;
        deleg_en  = 1'b1;
        for (int a = 'hB00; a < 'hB04; a++) begin
            apply(1'b0, 2'd3, 12'(a), 1'b0);
            apply(1'b0, 2'd0, 12'(a + 'h100), 1'b1);
        end
        apply(1'b0, 2'd1, 12'hC01, 1'b0);
        apply(1'b0, 2'd1, 12'hC01, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule